// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Unit

This unit is the front end of a small 16-bit processor with byte addresses. It fetches instructions one word at a time from a request/ready memory port. Each instruction is either one or two 16-bit words long. One bit of the first word says which. When that bit is set, the unit fetches a second word, which holds a constant or a memory address.

Every fetched word is captured first in a memory data register. It then moves into the instruction register, and the decode fields are taken from there. The program counter steps by one word after each accepted fetch. It therefore moves on by 2 or 4 bytes per instruction and always points at the next instruction.

Once an instruction is complete, the unit raises a one-cycle valid pulse. It then holds all decode fields steady until the execute stage acknowledges, and only then starts the next fetch. A halt opcode is presented like any other instruction, but after its acknowledge no further fetches are issued until reset.

Top module: `ifd_fetch_decode`

## Requirements
- R1: Reset is asynchronous and active low. After reset, `dec_valid` and `dec_halted` are 0, and the first request presents `mem_addr` equal to the start address parameter (default 16'h3000).
- R2: A request holds `mem_req` high with `mem_addr` unchanged until a rising edge where `mem_ready` is high. The word on `mem_rdata` at that edge is the one captured.
- R3: The opcode is bits 15:8 of the first word, the destination index is bits 3:2 and the source index is bits 1:0. Index codes 0 to 3 name r0 to r3. Bits 6:4 have no effect on any of these fields.
- R4: When bit 7 of the first word is 1, the second word is fetched from the first word's address + 2 and appears on `dec_ext_word`, and `dec_ext_flag` reads 1.
- R5: When bit 7 of the first word is 0, no second word is fetched, `dec_ext_flag` and `dec_ext_word` read 0, and the next instruction is fetched at the first word's address + 2.
- R6: After a two-word instruction, the next instruction is fetched at its first word's address + 4. For every instruction, `dec_next_pc` equals the address of the following instruction.
- R7: `dec_valid` is high for exactly one cycle per instruction. From that cycle until the cycle in which `dec_ack` is sampled high, the decode fields stay stable and `mem_req` stays low.
- R8: `dec_disp` equals the low byte of the first word. `dec_target` equals `dec_next_pc` plus that byte taken as 8-bit two's complement, modulo 2^16.
- R9: An instruction with opcode 8'hFF is presented normally. After its acknowledge, `mem_req` stays low and `dec_halted` stays 1 until reset.
- R10: Any number of wait cycles before `mem_ready` leaves the decoded results and the fetch address sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rdata | input | 16 | Word returned by memory |
| mem_ready | input | 1 | Memory has the word on mem_rdata this cycle |
| dec_valid | output | 1 | One-cycle pulse: a complete instruction is decoded |
| dec_ack | input | 1 | Execute stage accepts the presented instruction |
| dec_opcode | output | 8 | Operation code |
| dec_dst | output | 2 | Destination register index |
| dec_src | output | 2 | Source register index |
| dec_ext_flag | output | 1 | Instruction carries an extension word |
| dec_ext_word | output | 16 | Constant or memory address from the second word |
| dec_disp | output | 8 | Low byte of the first word (branch displacement) |
| dec_target | output | 16 | Next-instruction address plus sign-extended displacement |
| dec_next_pc | output | 16 | Address of the following instruction |
| dec_halted | output | 1 | Halt instruction retired; fetching stopped |

## Verification
The assertions assume that memory answers only a pending request: `mem_ready` is raised only while `mem_req` is high, and it is raised once per request. They also assume that `dec_ack` arrives only while an instruction is being presented.

The bench's memory model keeps to these assumptions. It asserts `mem_ready` on a falling edge only while a request is pending, drops it as soon as the request goes away, and uses a configurable latency. The bench pulses `dec_ack` only after it has seen `dec_valid`. It also releases reset away from the falling edge, so the model never answers a request issued while the unit is still in reset.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   typedef enum logic [2:0] {
      ST_FETCH_HEAD,
      ST_LOAD_HEAD,
      ST_FETCH_EXT,
      ST_LOAD_EXT,
      ST_PRESENT,
      ST_HALTED
   } ifd_state_e;

endpackage

// File: rtl/ifd_pc_unit.sv
module ifd_pc_unit #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned STEP_BYTES = 2,
   parameter int unsigned START_ADDR = 16'h3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] START_VAL = ADDR_W'(START_ADDR);
   localparam logic [ADDR_W-1:0] STEP_VAL  = ADDR_W'(STEP_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= START_VAL;
      else if (advance)
         pc <= pc + STEP_VAL;
   end

endmodule

// File: rtl/ifd_seq.sv
module ifd_seq
   import ifd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mem_ready,
   input  logic       mdr_ext_flag,
   input  logic       ir_is_halt,
   input  logic       dec_ack,
   output logic       mem_req,
   output logic       capture,
   output logic       load_head,
   output logic       load_ext,
   output logic       valid_pulse,
   output logic       halted
);

   ifd_state_e state_q, state_d;
   logic       valid_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_FETCH_HEAD: if (mem_ready) state_d = ST_LOAD_HEAD;
         ST_LOAD_HEAD:  state_d = mdr_ext_flag ? ST_FETCH_EXT : ST_PRESENT;
         ST_FETCH_EXT:  if (mem_ready) state_d = ST_LOAD_EXT;
         ST_LOAD_EXT:   state_d = ST_PRESENT;
         ST_PRESENT:    if (dec_ack) state_d = ir_is_halt ? ST_HALTED : ST_FETCH_HEAD;
         ST_HALTED:     state_d = ST_HALTED;
         default:       state_d = ST_FETCH_HEAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH_HEAD;
         valid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= (state_q != ST_PRESENT) && (state_d == ST_PRESENT);
      end
   end

   assign mem_req     = (state_q == ST_FETCH_HEAD) || (state_q == ST_FETCH_EXT);
   assign capture     = mem_req && mem_ready;
   assign load_head   = (state_q == ST_LOAD_HEAD);
   assign load_ext    = (state_q == ST_LOAD_EXT);
   assign valid_pulse = valid_q;
   assign halted      = (state_q == ST_HALTED);

endmodule

// File: rtl/ifd_ir.sv
module ifd_ir #(
   parameter int unsigned WORD_W    = 16,
   parameter bit          CLEAR_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              load_head,
   input  logic              load_ext,
   input  logic [WORD_W-1:0] rdata,
   output logic [WORD_W-1:0] mdr,
   output logic [WORD_W-1:0] ir_head,
   output logic [WORD_W-1:0] ir_ext
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mdr <= '0;
      else if (capture)
         mdr <= rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ir_head <= '0;
      else if (load_head)
         ir_head <= mdr;
   end

   generate
      if (CLEAR_EXT) begin : g_ext_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ir_ext <= '0;
            else if (load_head)
               ir_ext <= '0;
            else if (load_ext)
               ir_ext <= mdr;
         end
      end else begin : g_ext_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ir_ext <= '0;
            else if (load_ext)
               ir_ext <= mdr;
         end
      end
   endgenerate

endmodule

// File: rtl/ifd_decode.sv
module ifd_decode #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned OPC_W       = 8,
   parameter int unsigned RIDX_W      = 2,
   parameter int unsigned EXT_BIT     = 7,
   parameter int unsigned DISP_W      = 8,
   parameter int unsigned HALT_OPCODE = 8'hFF
) (
   input  logic [WORD_W-1:0] ir_head,
   input  logic [ADDR_W-1:0] next_pc,
   output logic [OPC_W-1:0]  opcode,
   output logic [RIDX_W-1:0] dst,
   output logic [RIDX_W-1:0] src,
   output logic              ext_flag,
   output logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target,
   output logic              is_halt
);

   localparam int unsigned      SEXT_W   = ADDR_W - DISP_W;
   localparam logic [OPC_W-1:0] HALT_VAL = OPC_W'(HALT_OPCODE);

   logic [ADDR_W-1:0] disp_ext;

   assign opcode   = ir_head[WORD_W-1 -: OPC_W];
   assign dst      = ir_head[2*RIDX_W-1 -: RIDX_W];
   assign src      = ir_head[RIDX_W-1:0];
   assign ext_flag = ir_head[EXT_BIT];
   assign disp     = ir_head[DISP_W-1:0];
   assign disp_ext = {{SEXT_W{disp[DISP_W-1]}}, disp};
   assign target   = next_pc + disp_ext;
   assign is_halt  = (opcode == HALT_VAL);

endmodule

// File: rtl/ifd_fetch_decode.sv
module ifd_fetch_decode #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned OPC_W       = 8,
   parameter int unsigned RIDX_W      = 2,
   parameter int unsigned EXT_BIT     = 7,
   parameter int unsigned DISP_W      = 8,
   parameter int unsigned START_ADDR  = 16'h3000,
   parameter int unsigned HALT_OPCODE = 8'hFF,
   parameter bit          CLEAR_EXT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              dec_valid,
   input  logic              dec_ack,
   output logic [OPC_W-1:0]  dec_opcode,
   output logic [RIDX_W-1:0] dec_dst,
   output logic [RIDX_W-1:0] dec_src,
   output logic              dec_ext_flag,
   output logic [WORD_W-1:0] dec_ext_word,
   output logic [DISP_W-1:0] dec_disp,
   output logic [ADDR_W-1:0] dec_target,
   output logic [ADDR_W-1:0] dec_next_pc,
   output logic              dec_halted
);

   localparam int unsigned STEP_BYTES = WORD_W / 8;
   localparam int unsigned LOW_W      = WORD_W - OPC_W;

   generate
      if (WORD_W % 8 != 0) begin : g_bad_word
         $error("WORD_W must be a whole number of bytes");
      end
      if (OPC_W >= WORD_W) begin : g_bad_opc
         $error("OPC_W must leave a low field");
      end
      if (EXT_BIT >= LOW_W || EXT_BIT < 2 * RIDX_W) begin : g_bad_ext
         $error("EXT_BIT must sit in the low field above the register indices");
      end
      if (DISP_W > LOW_W || DISP_W >= ADDR_W) begin : g_bad_disp
         $error("DISP_W must fit in the low field and be narrower than an address");
      end
      if (START_ADDR % STEP_BYTES != 0) begin : g_bad_start
         $error("START_ADDR must be word aligned");
      end
   endgenerate

   logic              capture, load_head, load_ext, is_halt;
   logic [WORD_W-1:0] mdr, ir_head, ir_ext;
   logic [ADDR_W-1:0] pc;

   ifd_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .mem_ready    (mem_ready),
      .mdr_ext_flag (mdr[EXT_BIT]),
      .ir_is_halt   (is_halt),
      .dec_ack      (dec_ack),
      .mem_req      (mem_req),
      .capture      (capture),
      .load_head    (load_head),
      .load_ext     (load_ext),
      .valid_pulse  (dec_valid),
      .halted       (dec_halted)
   );

   ifd_pc_unit #(
      .ADDR_W     (ADDR_W),
      .STEP_BYTES (STEP_BYTES),
      .START_ADDR (START_ADDR)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (capture),
      .pc      (pc)
   );

   ifd_ir #(
      .WORD_W    (WORD_W),
      .CLEAR_EXT (CLEAR_EXT)
   ) u_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .load_head (load_head),
      .load_ext  (load_ext),
      .rdata     (mem_rdata),
      .mdr       (mdr),
      .ir_head   (ir_head),
      .ir_ext    (ir_ext)
   );

   ifd_decode #(
      .ADDR_W      (ADDR_W),
      .WORD_W      (WORD_W),
      .OPC_W       (OPC_W),
      .RIDX_W      (RIDX_W),
      .EXT_BIT     (EXT_BIT),
      .DISP_W      (DISP_W),
      .HALT_OPCODE (HALT_OPCODE)
   ) u_dec (
      .ir_head  (ir_head),
      .next_pc  (pc),
      .opcode   (dec_opcode),
      .dst      (dec_dst),
      .src      (dec_src),
      .ext_flag (dec_ext_flag),
      .disp     (dec_disp),
      .target   (dec_target),
      .is_halt  (is_halt)
   );

   assign mem_addr     = pc;
   assign dec_ext_word = ir_ext;
   assign dec_next_pc  = pc;

endmodule

// File: rtl/ifd_fetch_decode_chk.sv
module ifd_fetch_decode_chk #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned OPC_W      = 8,
   parameter int unsigned START_ADDR = 16'h3000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready,
   input logic              dec_valid,
   input logic              dec_ack,
   input logic [OPC_W-1:0]  dec_opcode,
   input logic [WORD_W-1:0] dec_ext_word,
   input logic              dec_halted
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

   logic              seen_fetch;
   logic [ADDR_W-1:0] last_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_fetch <= 1'b0;
         last_addr  <= '0;
      end else if (mem_req && mem_ready) begin
         seen_fetch <= 1'b1;
         last_addr  <= mem_addr;
      end
   end

   assert_first_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !seen_fetch) |-> (mem_addr == ADDR_W'(START_ADDR)));

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && seen_fetch) |-> (mem_addr == last_addr + STEP));

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   assert_no_fetch_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> !mem_req);

   assert_hold_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ack) |=> ($stable(dec_opcode) && $stable(dec_ext_word) && !mem_req));

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_halted |=> (dec_halted && !mem_req));

endmodule

bind ifd_fetch_decode ifd_fetch_decode_chk #(
   .ADDR_W     (ADDR_W),
   .WORD_W     (WORD_W),
   .OPC_W      (OPC_W),
   .START_ADDR (START_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_ready    (mem_ready),
   .dec_valid    (dec_valid),
   .dec_ack      (dec_ack),
   .dec_opcode   (dec_opcode),
   .dec_ext_word (dec_ext_word),
   .dec_halted   (dec_halted)
);

// File: tb/ifd_fetch_decode_tb.sv
module ifd_fetch_decode_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = 16'hDEAD;
   logic        mem_ready = 1'b0;
   logic        dec_valid;
   logic        dec_ack = 1'b0;
   logic [7:0]  dec_opcode;
   logic [1:0]  dec_dst, dec_src;
   logic        dec_ext_flag;
   logic [15:0] dec_ext_word;
   logic [7:0]  dec_disp;
   logic [15:0] dec_target, dec_next_pc;
   logic        dec_halted;

   int checks = 0;
   int failures = 0;
   int latency = 0;
   int wait_cnt = 0;
   int addr_err = 0;
   int log_n = 0;
   logic [15:0] fetch_log [0:31];
   logic [15:0] held_addr;
   logic [15:0] mem [0:255];

   always #4 clk = ~clk;

   ifd_fetch_decode u_dut (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dec_valid(dec_valid),
      .dec_ack(dec_ack), .dec_opcode(dec_opcode), .dec_dst(dec_dst),
      .dec_src(dec_src), .dec_ext_flag(dec_ext_flag), .dec_ext_word(dec_ext_word),
      .dec_disp(dec_disp), .dec_target(dec_target), .dec_next_pc(dec_next_pc),
      .dec_halted(dec_halted)
   );

   // Memory model: answers a pending request after `latency` falling edges.
   always @(negedge clk) begin
      if (rst_n && mem_req && !mem_ready) begin
         if (wait_cnt > 0 && mem_addr != held_addr) addr_err++;
         if (wait_cnt == 0) held_addr = mem_addr;
         if (wait_cnt >= latency) begin
            mem_ready = 1'b1;
            mem_rdata = mem[8'((mem_addr - 16'h3000) >> 1)];
            if (log_n < 32) fetch_log[log_n] = mem_addr;
            log_n++;
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end else begin
         mem_ready = 1'b0;
         mem_rdata = 16'hDEAD;
         wait_cnt  = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_program();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      mem[0] = 16'h0180; mem[1] = 16'h0006;   // 3000: two-word, constant 6
      mem[2] = 16'h0284; mem[3] = 16'h0100;   // 3004: two-word, address 0100
      mem[4] = 16'h0F01;                      // 3008: one-word
      mem[5] = 16'h2F10;                      // 300A: one-word, +16
      mem[6] = 16'h2FF0; mem[7] = 16'hABCD;   // 300C: two-word, -16
      mem[8] = 16'h057F;                      // 3010: bits 6:4 set, bit 7 clear
      mem[9] = 16'hFF00;                      // 3012: halt
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      dec_ack = 1'b0;
      repeat (3) @(negedge clk);
      log_n = 0;
      addr_err = 0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: state right after reset release
      chk(mem_req == 1'b1, "R1 mem_req", 32'(mem_req), 1);
      chk(mem_addr == 16'h3000, "R1 start address", 32'(mem_addr), 32'h3000);
      chk(dec_valid == 1'b0 && dec_halted == 1'b0, "R1 valid/halted low",
          32'({dec_valid, dec_halted}), 0);
   endtask

   // Wait for one instruction, check fields (R3 R4 R5 R6 R8), hold for `hold` cycles, acknowledge.
   task automatic consume(input logic [15:0] head, input logic [15:0] ext,
                          input logic [15:0] next, input int hold);
      logic [15:0] exp_ext;
      logic [15:0] exp_tgt;
      int t = 0;
      while (!dec_valid && t < 400) begin @(negedge clk); t++; end
      chk(dec_valid == 1'b1, "R7 valid seen", 32'(dec_valid), 1);
      exp_ext = head[7] ? ext : 16'h0000;
      exp_tgt = next + {{8{head[7]}}, head[7:0]};
      chk(dec_opcode == head[15:8], "R3 opcode", 32'(dec_opcode), 32'(head[15:8]));
      chk(dec_dst == head[3:2] && dec_src == head[1:0], "R3 dst/src",
          32'({dec_dst, dec_src}), 32'({head[3:2], head[1:0]}));
      chk(dec_ext_flag == head[7], "R4 R5 ext flag", 32'(dec_ext_flag), 32'(head[7]));
      chk(dec_ext_word == exp_ext, "R4 R5 ext word", 32'(dec_ext_word), 32'(exp_ext));
      chk(dec_next_pc == next, "R6 next pc", 32'(dec_next_pc), 32'(next));
      chk(dec_disp == head[7:0], "R8 disp", 32'(dec_disp), 32'(head[7:0]));
      chk(dec_target == exp_tgt, "R8 target", 32'(dec_target), 32'(exp_tgt));
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk(dec_valid == 1'b0, "R7 valid one cycle", 32'(dec_valid), 0);
         chk(mem_req == 1'b0, "R7 no fetch before ack", 32'(mem_req), 0);
         chk(dec_opcode == head[15:8] && dec_ext_word == exp_ext, "R7 fields held",
             32'({dec_opcode, dec_ext_word}), 32'({head[15:8], exp_ext}));
      end
      dec_ack = 1'b1;
      @(negedge clk);
      dec_ack = 1'b0;
   endtask

   task automatic run_program(input int lat, input int hold);
      latency = lat;
      do_reset();
      consume(16'h0180, 16'h0006, 16'h3004, hold);
      consume(16'h0284, 16'h0100, 16'h3008, hold);
      consume(16'h0F01, 16'h0000, 16'h300A, hold);
      consume(16'h2F10, 16'h0000, 16'h300C, hold);
      consume(16'h2FF0, 16'hABCD, 16'h3010, hold);
      consume(16'h057F, 16'h0000, 16'h3012, hold);
      consume(16'hFF00, 16'h0000, 16'h3014, hold);
      repeat (12) begin
         @(negedge clk);
         chk(mem_req == 1'b0 && dec_halted == 1'b1, "R9 halted, no fetch",
             32'({mem_req, dec_halted}), 1);
      end
      chk(log_n == 10, "R5 R6 fetch count", 32'(log_n), 10);
      for (int i = 0; i < 10; i++)
         chk(fetch_log[i] == 16'h3000 + 16'(2 * i), "R4 R5 R6 fetch address",
             32'(fetch_log[i]), 32'h3000 + 32'(2 * i));
      chk(addr_err == 0, "R2 R10 address stable while waiting", 32'(addr_err), 0);
   endtask

   task automatic test_basic();
      run_program(0, 0);
   endtask

   task automatic test_wait_states();
      // R10: latency 3 must give identical results
      run_program(3, 0);
   endtask

   task automatic test_ack_delay();
      // R7: hold each instruction for 4 cycles before acknowledging
      run_program(1, 4);
   endtask

   task automatic test_midrun_reset();
      latency = 0;
      do_reset();
      consume(16'h0180, 16'h0006, 16'h3004, 0);
      consume(16'h0284, 16'h0100, 16'h3008, 0);
      do_reset();
      consume(16'h0180, 16'h0006, 16'h3004, 0);
      chk(fetch_log[0] == 16'h3000, "R1 restart address", 32'(fetch_log[0]), 32'h3000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      load_program();
      test_basic();
      test_wait_states();
      test_ack_delay();
      test_midrun_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule